// File: doc/BRIEF.md
# Priority Address Region Router

This block decides, for every memory access, which of three paths serves it: an auxiliary bus, an uncached bus or the cache path. It compares the access address with a set of programmable address windows. Each window has an inclusive lower bound and an inclusive upper bound. There are up to four auxiliary windows and up to four uncached windows. The decision is combinational on the address, so a pipeline stage can steer the request in the cycle it presents it.

The window bounds are held in registers that a control-register port reads and writes by fixed 12-bit numbers. The first window of each kind resets to values given by parameters, so a system with one contiguous peripheral range works out of reset. Two configurations need no windows at all: a system with no cache and only auxiliary windows, and a system with no cache and only uncached windows. In those cases the window registers are removed and every access takes the single remaining path.

Top module: `addr_region_router`

## Requirements
- R1: An address hits a window when it is unsigned greater than or equal to the window's lower bound and unsigned less than or equal to its upper bound, with both ends included.
- R2: An address that hits any auxiliary window is routed to the auxiliary bus. Otherwise, one that hits any uncached window goes to the uncached bus. Otherwise it goes to the cache path (when a cache is present).
- R3: A window whose lower bound is above its upper bound hits no address.
- R4: Auxiliary lower bounds use numbers 0xBD0+i and auxiliary upper bounds use 0xBD8+i. Uncached lower bounds use 0xBE0+i and uncached upper bounds use 0xBE8+i, for window i from 0 to 3. A write with `csr_we` high stores `csr_wdata`, and `csr_rdata` returns the stored value of the number on `csr_num`, combinationally.
- R5: A write changes routing from the cycle after the clock edge that stores it. In the cycle of the write, routing still uses the old bounds.
- R6: After reset, window 0 of each kind holds its parameter bounds. Every other implemented window holds lower bound 0xFFFFFFFF and upper bound 0, so it is disabled.
- R7: The registers of a window whose index is at or above the configured window count read as 0 and ignore writes. Any number outside the four ranges of R4 reads as 0.
- R8: With no cache and zero uncached windows, every access goes to the auxiliary bus, and all auxiliary window registers read 0 and ignore writes. With no cache and zero auxiliary windows, the same holds for the uncached bus and the uncached registers.
- R9: With no cache, an access that hits no window goes to the uncached bus.
- R10: `route_sel` is one-hot at all times: bit 0 selects the auxiliary bus, bit 1 the uncached bus and bit 2 the cache path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_addr | input | 32 | Address of the access being routed |
| csr_we | input | 1 | Write strobe of the register port |
| csr_num | input | 12 | Register number for read and write |
| csr_wdata | input | 32 | Write data |
| route_sel | output | 3 | One-hot path select (aux, uncached, cache) |
| csr_rdata | output | 32 | Read data for `csr_num` |

## Verification
The bench drives three copies of the block from the same stimulus. The first uses four auxiliary and four uncached windows with a cache, which covers overlapping windows, single-address windows and disabled windows. The second has no cache, one auxiliary window and two uncached windows, which covers unimplemented register slots and the fallback to the uncached bus. The third has no cache, two auxiliary windows and no uncached windows, which covers the collapsed auxiliary-only mode. Linear and high-bit address sweeps, plus probes at every bound and one past it, are compared against an arithmetic model of the programmed windows.

// File: rtl/arr_pkg.sv
// Package: shared constants and the route encoding of the region router.
// Assumes 32-bit addresses and 12-bit register numbers.
package arr_pkg;
    localparam int AW          = 32;
    localparam int CSR_W       = 12;
    localparam int MAX_REGIONS = 4;

    localparam logic [CSR_W-1:0] AUX_LO_NUM = 12'hBD0;
    localparam logic [CSR_W-1:0] AUX_HI_NUM = 12'hBD8;
    localparam logic [CSR_W-1:0] UC_LO_NUM  = 12'hBE0;
    localparam logic [CSR_W-1:0] UC_HI_NUM  = 12'hBE8;

    typedef enum logic [2:0] {
        ROUTE_AUX   = 3'b001,
        ROUTE_UC    = 3'b010,
        ROUTE_CACHE = 3'b100
    } route_t;
endpackage

// File: rtl/region_bank.sv
// Module: region_bank
// Holds the bound registers of one kind of address window and
// compares the access address against every implemented window.
// Slots at or above N_LIVE are not built: they never hit and read 0.
// Assumes LO_NUM and HI_NUM leave room for MAX_REGIONS numbers each.
module region_bank
    import arr_pkg::*;
#(
    parameter int               N_LIVE  = 4,
    parameter logic [CSR_W-1:0] LO_NUM  = AUX_LO_NUM,
    parameter logic [CSR_W-1:0] HI_NUM  = AUX_HI_NUM,
    parameter logic [AW-1:0]    RST_LO0 = '0,
    parameter logic [AW-1:0]    RST_HI0 = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          addr,
    input  logic                   csr_we,
    input  logic [CSR_W-1:0]       csr_num,
    input  logic [AW-1:0]          csr_wdata,
    output logic [MAX_REGIONS-1:0] hit_vec,
    output logic [AW-1:0]          rdata
);
    logic [MAX_REGIONS-1:0][AW-1:0] lo_v;
    logic [MAX_REGIONS-1:0][AW-1:0] hi_v;
    logic [MAX_REGIONS-1:0]         lo_sel;
    logic [MAX_REGIONS-1:0]         hi_sel;

    for (genvar i = 0; i < MAX_REGIONS; i++) begin : g_slot
        localparam logic [CSR_W-1:0] MY_LO = LO_NUM + CSR_W'(i);
        localparam logic [CSR_W-1:0] MY_HI = HI_NUM + CSR_W'(i);

        if (i < N_LIVE) begin : g_live
            localparam logic [AW-1:0] INIT_LO = (i == 0) ? RST_LO0 : '1;
            localparam logic [AW-1:0] INIT_HI = (i == 0) ? RST_HI0 : '0;
            logic [AW-1:0] lo_q;
            logic [AW-1:0] hi_q;

            // Bound registers: reset to defaults, load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_q <= INIT_LO;
                    hi_q <= INIT_HI;
                end else if (csr_we) begin
                    if (csr_num == MY_LO) lo_q <= csr_wdata;
                    if (csr_num == MY_HI) hi_q <= csr_wdata;
                end
            end

            assign lo_v[i]    = lo_q;
            assign hi_v[i]    = hi_q;
            assign lo_sel[i]  = (csr_num == MY_LO);
            assign hi_sel[i]  = (csr_num == MY_HI);
            assign hit_vec[i] = (addr >= lo_q) && (addr <= hi_q);
        end else begin : g_absent
            assign lo_v[i]    = '0;
            assign hi_v[i]    = '0;
            assign lo_sel[i]  = 1'b0;
            assign hi_sel[i]  = 1'b0;
            assign hit_vec[i] = 1'b0;
        end
    end

    // Read mux: OR of the selected register, zero when nothing is selected.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < MAX_REGIONS; k++) begin
            if (lo_sel[k]) rdata = rdata | lo_v[k];
            if (hi_sel[k]) rdata = rdata | hi_v[k];
        end
    end
endmodule

// File: rtl/route_priority.sv
// Module: route_priority
// Turns the two window-hit flags into a one-hot path select.
// Auxiliary outranks uncached, which outranks the cache. Without a
// cache the fallback is the uncached bus. The FORCE parameters pin the
// output when a configuration leaves only one path.
module route_priority
    import arr_pkg::*;
#(
    parameter bit CACHE_EN  = 1'b1,
    parameter bit FORCE_AUX = 1'b0,
    parameter bit FORCE_UC  = 1'b0
) (
    input  logic   aux_hit,
    input  logic   uc_hit,
    output route_t route
);
    // Priority decision of the path for the current access.
    always_comb begin
        if (FORCE_AUX)     route = ROUTE_AUX;
        else if (FORCE_UC) route = ROUTE_UC;
        else if (aux_hit)  route = ROUTE_AUX;
        else if (uc_hit)   route = ROUTE_UC;
        else if (CACHE_EN) route = ROUTE_CACHE;
        else               route = ROUTE_UC;
    end
endmodule

// File: rtl/addr_region_router.sv
// Module: addr_region_router (top)
// Routes each access address to the auxiliary bus, the uncached bus or
// the cache path, using programmable inclusive windows. The window
// bounds are read and written through a numbered register port.
// Assumes one register operation per cycle. A write affects routing
// from the next cycle on.
module addr_region_router
    import arr_pkg::*;
#(
    parameter int            AUX_REGIONS = 4,
    parameter int            UC_REGIONS  = 4,
    parameter bit            CACHE_EN    = 1'b1,
    parameter logic [AW-1:0] AUX0_LO     = 32'h8000_0000,
    parameter logic [AW-1:0] AUX0_HI     = 32'h8FFF_FFFF,
    parameter logic [AW-1:0] UC0_LO      = 32'h9000_0000,
    parameter logic [AW-1:0] UC0_HI      = 32'h9FFF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    acc_addr,
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_num,
    input  logic [AW-1:0]    csr_wdata,
    output logic [2:0]       route_sel,
    output logic [AW-1:0]    csr_rdata
);
    localparam bit AUX_ONLY = !CACHE_EN && (AUX_REGIONS > 0) && (UC_REGIONS == 0);
    localparam bit UC_ONLY  = !CACHE_EN && (UC_REGIONS > 0) && (AUX_REGIONS == 0);
    localparam int AUX_LIVE = AUX_ONLY ? 0 :
                              ((AUX_REGIONS > MAX_REGIONS) ? MAX_REGIONS : AUX_REGIONS);
    localparam int UC_LIVE  = UC_ONLY ? 0 :
                              ((UC_REGIONS > MAX_REGIONS) ? MAX_REGIONS : UC_REGIONS);

    logic [MAX_REGIONS-1:0] aux_vec;
    logic [MAX_REGIONS-1:0] uc_vec;
    logic [AW-1:0]          aux_rd;
    logic [AW-1:0]          uc_rd;
    logic                   aux_hit;
    logic                   uc_hit;
    route_t                 route;

    region_bank #(
        .N_LIVE (AUX_LIVE),
        .LO_NUM (AUX_LO_NUM),
        .HI_NUM (AUX_HI_NUM),
        .RST_LO0(AUX0_LO),
        .RST_HI0(AUX0_HI)
    ) u_aux_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (acc_addr),
        .csr_we   (csr_we),
        .csr_num  (csr_num),
        .csr_wdata(csr_wdata),
        .hit_vec  (aux_vec),
        .rdata    (aux_rd)
    );

    region_bank #(
        .N_LIVE (UC_LIVE),
        .LO_NUM (UC_LO_NUM),
        .HI_NUM (UC_HI_NUM),
        .RST_LO0(UC0_LO),
        .RST_HI0(UC0_HI)
    ) u_uc_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (acc_addr),
        .csr_we   (csr_we),
        .csr_num  (csr_num),
        .csr_wdata(csr_wdata),
        .hit_vec  (uc_vec),
        .rdata    (uc_rd)
    );

    assign aux_hit = |aux_vec;
    assign uc_hit  = |uc_vec;

    route_priority #(
        .CACHE_EN (CACHE_EN),
        .FORCE_AUX(AUX_ONLY),
        .FORCE_UC (UC_ONLY)
    ) u_prio (
        .aux_hit(aux_hit),
        .uc_hit (uc_hit),
        .route  (route)
    );

    // Output drive: one-hot select and merged register read data.
    assign route_sel = route;
    assign csr_rdata = aux_rd | uc_rd;
endmodule

// File: rtl/addr_region_router_chk.sv
// Module: addr_region_router_chk
// Property checker bound into addr_region_router. It watches the
// ports and the window-hit flags that the banks drive.
module addr_region_router_chk #(
    parameter bit CACHE_EN = 1'b1,
    parameter bit AUX_ONLY = 1'b0,
    parameter int AUX_LIVE = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_we,
    input logic [11:0] csr_num,
    input logic [31:0] csr_wdata,
    input logic [2:0]  route_sel,
    input logic [31:0] csr_rdata,
    input logic        aux_hit,
    input logic        uc_hit
);
    // R10: exactly one path is selected.
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(route_sel) == 1);

    // R2: an auxiliary hit wins.
    a_r2_aux_first: assert property (@(posedge clk) disable iff (!rst_n)
        aux_hit |-> route_sel == 3'b001);

    // R2: an uncached hit wins over the cache.
    a_r2_uc_second: assert property (@(posedge clk) disable iff (!rst_n)
        (uc_hit && !aux_hit) |-> route_sel == 3'b010);

    if (!CACHE_EN) begin : g_nocache
        // R9: with no cache the cache path is never selected.
        a_r9_no_cache_path: assert property (@(posedge clk) disable iff (!rst_n)
            route_sel[2] == 1'b0);
    end

    if (AUX_ONLY) begin : g_auxonly
        // R8: collapsed mode sends everything to the auxiliary bus.
        a_r8_all_aux: assert property (@(posedge clk) disable iff (!rst_n)
            route_sel == 3'b001);
        // R8: the removed registers read as zero.
        a_r8_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_num[11:4] == 8'hBD) |-> csr_rdata == 32'h0);
    end

    if (AUX_LIVE > 0) begin : g_readback
        // R4: a stored lower bound of window 0 reads back the next cycle.
        a_r4_readback: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(csr_we) && $past(csr_num) == 12'hBD0 && !csr_we && csr_num == 12'hBD0)
            |-> csr_rdata == $past(csr_wdata));
    end
endmodule

bind addr_region_router addr_region_router_chk #(
    .CACHE_EN(CACHE_EN),
    .AUX_ONLY(AUX_ONLY),
    .AUX_LIVE(AUX_LIVE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_we   (csr_we),
    .csr_num  (csr_num),
    .csr_wdata(csr_wdata),
    .route_sel(route_sel),
    .csr_rdata(csr_rdata),
    .aux_hit  (aux_hit),
    .uc_hit   (uc_hit)
);

// File: tb/addr_region_router_tb.sv
`timescale 1ns/1ps
module addr_region_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_num = '0;
    logic [31:0] csr_wdata = '0;
    logic [2:0]  rt_dut, rt_nc, rt_na;
    logic [31:0] rd_dut, rd_nc, rd_na;

    int n_checks = 0;
    int n_errors = 0;

    // Model of window bounds: index 0-3 auxiliary, 4-7 uncached.
    logic [31:0] mlo [8];
    logic [31:0] mhi [8];

    always #10 clk = ~clk;

    addr_region_router u_dut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .csr_we(csr_we),
        .csr_num(csr_num), .csr_wdata(csr_wdata), .route_sel(rt_dut), .csr_rdata(rd_dut));

    addr_region_router #(.AUX_REGIONS(1), .UC_REGIONS(2), .CACHE_EN(1'b0)) u_nc (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .csr_we(csr_we),
        .csr_num(csr_num), .csr_wdata(csr_wdata), .route_sel(rt_nc), .csr_rdata(rd_nc));

    addr_region_router #(.AUX_REGIONS(2), .UC_REGIONS(0), .CACHE_EN(1'b0)) u_na (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .csr_we(csr_we),
        .csr_num(csr_num), .csr_wdata(csr_wdata), .route_sel(rt_na), .csr_rdata(rd_na));

    function automatic logic [2:0] exp_route(input logic [31:0] a, input int na,
                                             input int nu, input bit cache, input bit aonly);
        bit ah = 1'b0;
        bit uh = 1'b0;
        if (aonly) return 3'b001;
        for (int i = 0; i < 4; i++) begin
            if (i < na && a >= mlo[i] && a <= mhi[i]) ah = 1'b1;
            if (i < nu && a >= mlo[4+i] && a <= mhi[4+i]) uh = 1'b1;
        end
        if (ah) return 3'b001;
        if (uh) return 3'b010;
        return cache ? 3'b100 : 3'b010;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] n, input int na, input int nu);
        for (int i = 0; i < 4; i++) begin
            if (i < na && n == 12'hBD0 + 12'(i)) return mlo[i];
            if (i < na && n == 12'hBD8 + 12'(i)) return mhi[i];
            if (i < nu && n == 12'hBE0 + 12'(i)) return mlo[4+i];
            if (i < nu && n == 12'hBE8 + 12'(i)) return mhi[4+i];
        end
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got %h expected %h (addr %h num %h)", tag, got, exp, acc_addr, csr_num);
        end
    endtask

    task automatic check_routes(input string tag);
        chk({tag, " dut"}, 32'(rt_dut), 32'(exp_route(acc_addr, 4, 4, 1'b1, 1'b0)));
        chk({tag, " nc R9"}, 32'(rt_nc), 32'(exp_route(acc_addr, 1, 2, 1'b0, 1'b0)));
        chk({tag, " na R8"}, 32'(rt_na), 32'(exp_route(acc_addr, 0, 0, 1'b0, 1'b1)));
    endtask

    // R1 R2 R3 R9 R10: route one address on all three copies.
    task automatic probe(input logic [31:0] a);
        @(negedge clk);
        acc_addr = a;
        #2;
        check_routes("R1 R2 R3 R10 route");
    endtask

    // R4 R6 R7 R8: read one register number on all three copies.
    task automatic rd(input logic [11:0] n, input string tag);
        @(negedge clk);
        csr_num = n;
        #2;
        chk({tag, " dut R4"}, rd_dut, exp_read(n, 4, 4));
        chk({tag, " nc R7"}, rd_nc, exp_read(n, 1, 2));
        chk({tag, " na R8"}, rd_na, 32'h0);
    endtask

    // R5: write; routing before the edge uses old bounds, after uses new.
    task automatic wr(input logic [11:0] n, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1;
        csr_num = n;
        csr_wdata = d;
        #2;
        check_routes("R5 old");
        @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) begin
            if (n == 12'hBD0 + 12'(i)) mlo[i] = d;
            if (n == 12'hBD8 + 12'(i)) mhi[i] = d;
            if (n == 12'hBE0 + 12'(i)) mlo[4+i] = d;
            if (n == 12'hBE8 + 12'(i)) mhi[4+i] = d;
        end
        @(negedge clk);
        csr_we = 1'b0;
        #2;
        check_routes("R5 new");
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 4; i++) begin
            rd(12'hBD0 + 12'(i), tag);
            rd(12'hBD8 + 12'(i), tag);
            rd(12'hBE0 + 12'(i), tag);
            rd(12'hBE8 + 12'(i), tag);
        end
        rd(12'hBD4, {tag, " R7 gap"});
        rd(12'hBEC, {tag, " R7 gap"});
        rd(12'h300, {tag, " R7 other"});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            mlo[i] = 32'hFFFF_FFFF;
            mhi[i] = 32'h0;
        end
        mlo[0] = 32'h8000_0000; mhi[0] = 32'h8FFF_FFFF;
        mlo[4] = 32'h9000_0000; mhi[4] = 32'h9FFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset contents and reset routing.
        read_all("R6 reset");
        probe(32'h8000_0000);
        probe(32'h9FFF_FFFF);
        probe(32'h0000_1000);

        // Program windows: overlaps, single address, disabled, top edge.
        wr(12'hBD1, 32'h0000_1000); wr(12'hBD9, 32'h0000_1FFF);
        wr(12'hBD2, 32'h0000_3000); wr(12'hBDA, 32'h0000_3000);
        wr(12'hBD3, 32'h0000_5000); wr(12'hBDB, 32'h0000_4FFF);
        wr(12'hBE0, 32'h0000_0800); wr(12'hBE8, 32'h0000_17FF);
        wr(12'hBE1, 32'h0000_4000); wr(12'hBE9, 32'h0000_4FFF);
        wr(12'hBE2, 32'h0000_2FFF); wr(12'hBEA, 32'h0000_3001);
        wr(12'hBE3, 32'hFFFF_FF00); wr(12'hBEB, 32'hFFFF_FFFF);
        // R7: unknown number write must not disturb anything.
        wr(12'hBD4, 32'h0000_0000);
        read_all("R4 programmed");

        // R1 R3: every bound and its neighbours.
        for (int j = 0; j < 8; j++) begin
            probe(mlo[j] - 32'd1);
            probe(mlo[j]);
            probe(mhi[j]);
            probe(mhi[j] + 32'd1);
        end
        // R2: linear sweep over the overlapping low range.
        for (int k = 0; k < 1536; k++) probe(32'(k) * 32'd16);
        // R9 R10: high-bit sweep.
        for (int k = 0; k < 256; k++) probe(32'(k) << 24);

        // R5: move window 0 of the auxiliary kind over a cache-routed address.
        @(negedge clk);
        acc_addr = 32'h7000_0000;
        wr(12'hBD0, 32'h7000_0000);
        rd(12'hBD0, "R5 readback");
        // R3: disable it by crossing the bounds.
        wr(12'hBD8, 32'h6FFF_FFFF);
        probe(32'h7000_0000);
        probe(32'h6FFF_FFFF);

        finish_run();
    end
endmodule